// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block sits between a single-request synchronous host port and an asynchronous pseudo-static RAM with 128K words of 16 bits. The host raises a request for one cycle and supplies a write flag, a word address, write data and a byte-lane mask. The controller then runs one complete memory cycle on the active-low strobes. It reports completion with a one-cycle done pulse. For a read, the captured data is presented with that pulse.

The memory strobes are held for a fixed number of clock cycles. That count is derived from the memory's 70 ns access time and the clock period. The address, the strobes and the lane selects stay unchanged for the whole access, because the memory does not tolerate an address change once a read is under way. The shared data bus is driven only while a write is in progress. In every other state it is released to the memory.

The controller is a single state machine with these states:
- IDLE: chip deselected, waiting for a request.
- WSETUP: write data is placed on the bus and the chip is selected.
- WPULSE: write enable is held low for the wait count.
- WHOLD: write enable is high again, and data and select are held for one cycle.
- RACCESS: chip select and output enable are held low for the wait count.
- DONE: the done pulse is given, with the chip deselected.

Transitions:
- IDLE→WSETUP on a write request with at least one lane.
- IDLE→RACCESS on a read request with at least one lane.
- IDLE→DONE on a request with no lanes.
- WSETUP→WPULSE after one cycle.
- WPULSE→WHOLD and RACCESS→DONE when the wait timer expires.
- WHOLD→DONE after one cycle.
- DONE→IDLE after one cycle.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access under way (IDLE and DONE), the following hold: `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_lane_n` is all ones, and `host_done` is 0 outside DONE.
- R2: A request is accepted only in IDLE. A request raised while an access is running is dropped: it produces no memory cycle and no done pulse.
- R3: Take a write request accepted at clock edge 0. Then `mem_cs_n` is low in cycles 1 to 10 and the bus carries the write data in cycles 1 to 10. `mem_we_n` is low in cycles 2 to 9, which is a wait count of 8 at the default 10 ns clock (ceil(70 ns / period) + 1). `host_done` is high in cycle 11. `mem_oe_n` stays high throughout.
- R4: `host_lanes` bit 0 selects bits 7:0 and bit 1 selects bits 15:8. During an access, `mem_lane_n[i]` is the inverse of the latched `host_lanes[i]`. A write changes only the enabled bytes of the addressed word.
- R5: Take a read request accepted at clock edge 0. Then `mem_cs_n` and `mem_oe_n` are low in cycles 1 to 8 with `mem_we_n` high, and `host_done` is high in cycle 9. `mem_addr` equals the requested 17-bit address and does not change during the access.
- R6: On a read, `host_rdata` in the done cycle holds the bus value sampled in the last cycle of the access for enabled lanes, and zero for disabled lanes.
- R7: The controller drives `mem_dq` only in WSETUP, WPULSE and WHOLD, never while `mem_oe_n` is low. A read therefore returns exactly the data the memory presents.
- R8: A request with `host_lanes` all zero gives `host_done` in cycle 1, never lowers `mem_cs_n`, and leaves memory contents unchanged.
- R9: `host_done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, sampled in IDLE |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_lanes | input | 2 | Byte-lane mask, bit 0 = bits 7:0 |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_done |
| mem_cs_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lane_n | output | 2 | Byte selects, active low, bit 0 = low byte |
| mem_addr | output | 17 | Memory word address |
| mem_dq | inout | 16 | Shared data bus |

## Verification
The controller is exercised with the following request patterns:
- Full-word writes and reads. These pin the cycle positions of each strobe and the done pulse.
- Low-lane-only and high-lane-only writes followed by full reads. These separate correct per-byte merging from whole-word overwrites or swapped lanes.
- A single-lane read. This shows whether disabled lanes are masked.
- A request with no lanes. This separates a skipped access from a real one.
- A second request injected while a write is running. This shows whether the busy controller drops it.
- An access at the highest address. This checks that all 17 address bits reach the memory.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_DONE
    } psram_state_e;

    function automatic int wait_cycles(input int period_ps, input int access_ps);
        return (access_ps + period_ps - 1) / period_ps + 1;
    endfunction

endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = (cnt_q == LAST);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/psram_lane_capture.sv
module psram_lane_capture #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LANES-1:0]   lane_en,
    input  logic [8*LANES-1:0] bus_in,
    output logic [8*LANES-1:0] data_q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_q[8*l +: 8] <= '0;
            else if (load)
                data_q[8*l +: 8] <= lane_en[l] ? bus_in[8*l +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int LANES         = 2,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int ACCESS_PS     = 70000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_write,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [8*LANES-1:0] host_wdata,
    input  logic [LANES-1:0]   host_lanes,
    output logic               host_done,
    output logic [8*LANES-1:0] host_rdata,
    output logic               mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [LANES-1:0]   mem_lane_n,
    output logic [ADDR_W-1:0]  mem_addr,
    inout  wire  [8*LANES-1:0] mem_dq
);
    localparam int DATA_W   = 8 * LANES;
    localparam int WAIT_CYC = wait_cycles(CLK_PERIOD_PS, ACCESS_PS);

    psram_state_e        state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    lanes_q;
    logic                tmr_clr, tmr_expire;
    logic                bus_drv;
    logic                accept;

    assign accept = (state_q == ST_IDLE) && host_req;

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
                lanes_q <= host_lanes;
            end
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_lanes == '0)
                        state_d = ST_DONE;
                    else if (host_write)
                        state_d = ST_WSETUP;
                    else
                        state_d = ST_RACCESS;
                end
            end
            ST_WSETUP:  state_d = ST_WPULSE;
            ST_WPULSE:  if (tmr_expire) state_d = ST_WHOLD;
            ST_WHOLD:   state_d = ST_DONE;
            ST_RACCESS: if (tmr_expire) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr = (state_d != state_q);

    psram_wait_timer #(.LIMIT(WAIT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .expire (tmr_expire)
    );

    // Output decode
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_lane_n = '1;
        bus_drv    = 1'b0;
        host_done  = 1'b0;
        unique case (state_q)
            ST_WSETUP, ST_WHOLD: begin
                mem_cs_n   = 1'b0;
                mem_lane_n = ~lanes_q;
                bus_drv    = 1'b1;
            end
            ST_WPULSE: begin
                mem_cs_n   = 1'b0;
                mem_we_n   = 1'b0;
                mem_lane_n = ~lanes_q;
                bus_drv    = 1'b1;
            end
            ST_RACCESS: begin
                mem_cs_n   = 1'b0;
                mem_oe_n   = 1'b0;
                mem_lane_n = ~lanes_q;
            end
            ST_DONE:  host_done = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dq   = bus_drv ? wdata_q : {DATA_W{1'bz}};

    psram_lane_capture #(.LANES(LANES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state_q == ST_RACCESS) && tmr_expire),
        .lane_en (lanes_q),
        .bus_in  (mem_dq),
        .data_q  (host_rdata)
    );

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5
    AST_BUS_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_drv && !mem_oe_n)); // R7
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R5
    AST_DATA_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(bus_drv)); // R3
    AST_DATA_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (bus_drv && !mem_cs_n)); // R3
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done); // R9
    AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (mem_cs_n && mem_lane_n == '1)); // R1

endmodule

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [16:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_lanes = '0;
    logic        host_done;
    logic [15:0] host_rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_lane_n;
    logic [16:0] mem_addr;
    wire  [15:0] mem_dq;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_lanes(host_lanes),
        .host_done(host_done), .host_rdata(host_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // Behavioural memory model
    logic [15:0] mem [0:1023];
    logic        rd_on;
    assign rd_on = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_on && !mem_lane_n[0]) ? mem[mem_addr[9:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_on && !mem_lane_n[1]) ? mem[mem_addr[9:0]][15:8] : 8'hzz;

    always @(posedge mem_we_n) begin
        if (!mem_cs_n) begin
            if (!mem_lane_n[0]) mem[mem_addr[9:0]][7:0]  <= mem_dq[7:0];
            if (!mem_lane_n[1]) mem[mem_addr[9:0]][15:8] <= mem_dq[15:8];
        end
    end

    function automatic logic [15:0] init_word(input int i);
        return 16'hA000 ^ 16'(i);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-access observations
    int          o_done_at, o_done_cnt, o_first_we, o_we_cnt, o_oe_cnt, o_cs_cnt, o_addr_bad, o_lane_bad;
    logic [15:0] o_rdata;

    task automatic access(input bit wr, input logic [16:0] a, input logic [15:0] d,
                          input logic [1:0] ln, input int inj_k,
                          input logic [16:0] inj_a, input logic [15:0] inj_d);
        o_done_at = -1; o_done_cnt = 0; o_first_we = -1; o_we_cnt = 0;
        o_oe_cnt = 0; o_cs_cnt = 0; o_addr_bad = 0; o_lane_bad = 0; o_rdata = '0;
        @(negedge clk);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d; host_lanes = ln;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (k == 1) begin
                host_req = 1'b0; host_addr = '0; host_wdata = '0; host_lanes = '0;
            end
            if (k == inj_k) begin
                host_req = 1'b1; host_write = 1'b1; host_addr = inj_a;
                host_wdata = inj_d; host_lanes = 2'b11;
            end
            if (k == inj_k + 1) begin
                host_req = 1'b0; host_lanes = '0;
            end
            if (host_done) begin
                o_done_cnt++;
                if (o_done_at < 0) begin o_done_at = k; o_rdata = host_rdata; end
            end
            if (!mem_we_n) begin
                o_we_cnt++;
                if (o_first_we < 0) o_first_we = k;
            end
            if (!mem_oe_n) o_oe_cnt++;
            if (!mem_cs_n) begin
                o_cs_cnt++;
                if (mem_addr != a) o_addr_bad++;
                if (mem_lane_n != ~ln) o_lane_bad++;
            end
        end
    endtask

    task automatic t_reset;
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high after reset",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(mem_lane_n == 2'b11, "R1 lanes high after reset", mem_lane_n, 2'b11);
        chk(!host_done, "R1 done low after reset", host_done, 0);
    endtask

    task automatic t_write_read_full;
        access(1'b1, 17'h10005, 16'h1234, 2'b11, 0, '0, '0);
        chk(o_done_at == 11, "R3 write done cycle", o_done_at, 11);
        chk(o_first_we == 2, "R3 we falls after data setup", o_first_we, 2);
        chk(o_we_cnt == 8, "R3 we low length", o_we_cnt, 8);
        chk(o_oe_cnt == 0, "R3 oe high during write", o_oe_cnt, 0);
        chk(o_cs_cnt == 10, "R1 cs released at done", o_cs_cnt, 10);
        chk(o_done_cnt == 1, "R9 single done on write", o_done_cnt, 1);
        chk(o_lane_bad == 0, "R4 lane selects on full write", o_lane_bad, 0);
        access(1'b0, 17'h10005, '0, 2'b11, 0, '0, '0);
        chk(o_done_at == 9, "R5 read done cycle", o_done_at, 9);
        chk(o_oe_cnt == 8 && o_cs_cnt == 8, "R5 read strobe length", o_oe_cnt, 8);
        chk(o_we_cnt == 0, "R5 we high during read", o_we_cnt, 0);
        chk(o_addr_bad == 0, "R5 address held", o_addr_bad, 0);
        chk(o_done_cnt == 1, "R9 single done on read", o_done_cnt, 1);
        chk(o_rdata == 16'h1234, "R6 R7 read data", o_rdata, 16'h1234);
    endtask

    task automatic t_lanes;
        access(1'b1, 17'h10005, 16'h77AB, 2'b01, 0, '0, '0);
        chk(o_lane_bad == 0, "R4 low lane select", o_lane_bad, 0);
        access(1'b0, 17'h10005, '0, 2'b11, 0, '0, '0);
        chk(o_rdata == 16'h12AB, "R4 low byte only written", o_rdata, 16'h12AB);
        access(1'b1, 17'h10005, 16'hCD66, 2'b10, 0, '0, '0);
        chk(o_lane_bad == 0, "R4 high lane select", o_lane_bad, 0);
        access(1'b0, 17'h10005, '0, 2'b11, 0, '0, '0);
        chk(o_rdata == 16'hCDAB, "R4 high byte only written", o_rdata, 16'hCDAB);
        access(1'b0, 17'h10005, '0, 2'b01, 0, '0, '0);
        chk(o_rdata == 16'h00AB, "R6 disabled lane reads zero", o_rdata, 16'h00AB);
        access(1'b0, 17'h10005, '0, 2'b10, 0, '0, '0);
        chk(o_rdata == 16'hCD00, "R6 low lane masked", o_rdata, 16'hCD00);
    endtask

    task automatic t_no_lanes;
        access(1'b1, 17'h10005, 16'hFFFF, 2'b00, 0, '0, '0);
        chk(o_done_at == 1, "R8 empty request done cycle", o_done_at, 1);
        chk(o_cs_cnt == 0, "R8 no chip select", o_cs_cnt, 0);
        chk(o_done_cnt == 1, "R9 single done on empty request", o_done_cnt, 1);
        access(1'b0, 17'h10005, '0, 2'b11, 0, '0, '0);
        chk(o_rdata == 16'hCDAB, "R8 memory untouched", o_rdata, 16'hCDAB);
    endtask

    task automatic t_busy;
        access(1'b1, 17'h00020, 16'h5555, 2'b11, 3, 17'h00040, 16'h9999);
        chk(o_done_cnt == 1, "R2 no done for dropped request", o_done_cnt, 1);
        chk(o_addr_bad == 0, "R2 address not disturbed", o_addr_bad, 0);
        access(1'b0, 17'h00040, '0, 2'b11, 0, '0, '0);
        chk(o_rdata == init_word(16'h40), "R2 dropped write not performed", o_rdata, init_word(16'h40));
        access(1'b0, 17'h00020, '0, 2'b11, 0, '0, '0);
        chk(o_rdata == 16'h5555, "R2 running write completed", o_rdata, 16'h5555);
    endtask

    task automatic t_top_addr;
        access(1'b1, 17'h1FFFF, 16'hBEEF, 2'b11, 0, '0, '0);
        chk(o_addr_bad == 0, "R5 full address on write", o_addr_bad, 0);
        access(1'b0, 17'h1FFFF, '0, 2'b11, 0, '0, '0);
        chk(o_addr_bad == 0, "R5 full address on read", o_addr_bad, 0);
        chk(o_rdata == 16'hBEEF, "R6 top address data", o_rdata, 16'hBEEF);
        chk(mem_cs_n && host_done == 1'b0, "R1 idle after accesses", mem_cs_n, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read_full();
        t_lanes();
        t_no_lanes();
        t_busy();
        t_top_addr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule